// File: doc/BRIEF.md
# Multi-Track Peak Interval Timer

This block measures the spacing between peaks on the three tracks of a magnetic stripe read head. Each track has its own interval counter that steps once per ADC sample strobe. When the peak detector flags a peak on a track, the block sends the sample count since that track's previous peak to a downstream FIFO as a delta-time word, and the counter starts again from zero. The FIFO and the register interface are outside this block.

A shared maximum count marks the end of a swipe. When a track's counter reaches it, the block writes a final delta-time word, pulses a time-out for that track and parks the counter, so no further time-outs come from that track. The next threshold crossing on the parked track starts it again. A card time-out pulse fires when a track times out and no other enabled track is still timing. Software can therefore take one interrupt per card instead of one per track. Per-track and card time-out outputs each have their own enable.

Top module: `pit_timer`

## Requirements
- R1: While rst_ni is low and after it is released, all tracks are in the never-started state and dt_we_o, to_o and card_to_o are low.
- R2: A track that has never seen a peak does not count and raises no output. The first peak on it emits no delta-time word; it starts the interval counter at zero.
- R3: On a peak, a timing track asserts its bit of dt_we_o for one cycle. Its 12-bit field of dt_data_o (track n at bits 12n+11..12n) carries the number of sample strobes since the previous peak, counting the peak's own strobe. The counter restarts from zero on that strobe. Cycles without sample_i do not count.
- R4: When the elapsed count of a timing track reaches max_cnt_i (assumed at least 1), the track times out on that strobe. It writes a delta-time word equal to max_cnt_i and pulses its time-out bit. A peak on the same strobe takes priority and is reported as a normal delta.
- R5: A timed-out track raises no further time-outs and no delta-time words, and peaks on it are ignored.
- R6: A threshold crossing on a timed-out track re-arms it, with the counter at zero on that strobe. A crossing on a track that is timing or never started has no effect.
- R7: card_to_o pulses on a track time-out only if every other track is disabled, timed out, never started, or also timing out on the same strobe.
- R8: When several tracks time out on the same strobe, exactly one single-cycle card_to_o pulse is produced.
- R9: to_ien_i[n] gates to_o[n], and card_ien_i gates card_to_o. Neither enable affects the delta-time words.
- R10: A track whose bit of trk_en_i is low returns to the never-started state, raises no output, and counts as inactive for the card time-out.
- R11: Outputs are registered. They appear in the cycle after the strobe that causes them and last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | ADC sample strobe |
| peak_i | input | 3 | Per-track peak pulse, valid with sample_i |
| xing_i | input | 3 | Per-track threshold-crossing pulse, valid with sample_i |
| trk_en_i | input | 3 | Per-track enable |
| max_cnt_i | input | 12 | Shared maximum count (time-out limit) |
| to_ien_i | input | 3 | Per-track time-out output enable |
| card_ien_i | input | 1 | Card time-out output enable |
| dt_we_o | output | 3 | Per-track delta-time write strobe |
| dt_data_o | output | 36 | Delta-time words, 12 bits per track |
| to_o | output | 3 | Per-track time-out pulse |
| card_to_o | output | 1 | Card time-out pulse |

## Verification
The assertions rely on three things about the inputs. Peak and crossing pulses arrive only together with a sample strobe. max_cnt_i is at least 1 and does not change while a track is timing. Under these conditions every delta word is non-zero, a time-out always comes with a write, and neither a track nor the card can time out on two cycles in a row. The bench drives peaks and crossings only through a task that also raises the strobe, and it sets max_cnt_i only right after reset, while all tracks are idle.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_RUN  = 2'd1,
    TRK_PARK = 2'd2
  } trk_state_e;
endpackage

// File: rtl/pit_track.sv
module pit_track
  import pit_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             sample_i,
  input  logic             peak_i,
  input  logic             xing_i,
  input  logic [CNT_W-1:0] max_cnt_i,
  output logic             we_o,
  output logic [CNT_W-1:0] data_o,
  output logic             to_now_o,
  output logic             busy_nxt_o
);
  localparam int EXT_W = CNT_W + 1;

  trk_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] data_n;
  logic             we_n;
  logic [EXT_W-1:0] cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + EXT_W'(1);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    we_n     = 1'b0;
    data_n   = data_o;
    to_now_o = 1'b0;
    if (!en_i) begin
      state_n = TRK_IDLE;
      cnt_n   = '0;
    end else if (sample_i) begin
      unique case (state_q)
        TRK_IDLE: if (peak_i) begin
          state_n = TRK_RUN;
          cnt_n   = '0;
        end
        TRK_RUN: begin
          if (peak_i) begin
            we_n   = 1'b1;
            data_n = cnt_inc[CNT_W-1:0];
            cnt_n  = '0;
          end else if (cnt_inc >= {1'b0, max_cnt_i}) begin
            // end of swipe: flush last interval, park
            we_n     = 1'b1;
            data_n   = cnt_inc[CNT_W-1:0];
            to_now_o = 1'b1;
            state_n  = TRK_PARK;
            cnt_n    = '0;
          end else begin
            cnt_n = cnt_inc[CNT_W-1:0];
          end
        end
        TRK_PARK: if (xing_i) begin
          state_n = TRK_RUN;
          cnt_n   = '0;
        end
        default: state_n = TRK_IDLE;
      endcase
    end
  end

  assign busy_nxt_o = (state_n == TRK_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TRK_IDLE;
      cnt_q   <= '0;
      we_o    <= 1'b0;
      data_o  <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      we_o    <= we_n;
      data_o  <= data_n;
    end
  end
endmodule

// File: rtl/pit_evt.sv
module pit_evt #(
  parameter int NUM_TRK = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_TRK-1:0] to_now_i,
  input  logic [NUM_TRK-1:0] busy_nxt_i,
  input  logic [NUM_TRK-1:0] to_ien_i,
  input  logic               card_ien_i,
  output logic [NUM_TRK-1:0] to_o,
  output logic               card_to_o
);
  logic card_evt;

  // last track: someone timed out and nobody remains timing
  assign card_evt = (|to_now_i) && !(|busy_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      to_o      <= '0;
      card_to_o <= 1'b0;
    end else begin
      to_o      <= to_now_i & to_ien_i;
      card_to_o <= card_evt & card_ien_i;
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int NUM_TRK = 3,
  parameter int CNT_W   = 12
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic [NUM_TRK-1:0]       peak_i,
  input  logic [NUM_TRK-1:0]       xing_i,
  input  logic [NUM_TRK-1:0]       trk_en_i,
  input  logic [CNT_W-1:0]         max_cnt_i,
  input  logic [NUM_TRK-1:0]       to_ien_i,
  input  logic                     card_ien_i,
  output logic [NUM_TRK-1:0]       dt_we_o,
  output logic [NUM_TRK*CNT_W-1:0] dt_data_o,
  output logic [NUM_TRK-1:0]       to_o,
  output logic                     card_to_o
);
  logic [NUM_TRK-1:0] to_now;
  logic [NUM_TRK-1:0] busy_nxt;

  for (genvar g = 0; g < NUM_TRK; g++) begin : g_trk
    pit_track #(.CNT_W(CNT_W)) u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (trk_en_i[g]),
      .sample_i   (sample_i),
      .peak_i     (peak_i[g]),
      .xing_i     (xing_i[g]),
      .max_cnt_i  (max_cnt_i),
      .we_o       (dt_we_o[g]),
      .data_o     (dt_data_o[g*CNT_W +: CNT_W]),
      .to_now_o   (to_now[g]),
      .busy_nxt_o (busy_nxt[g])
    );
  end

  pit_evt #(.NUM_TRK(NUM_TRK)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .to_now_i   (to_now),
    .busy_nxt_i (busy_nxt),
    .to_ien_i   (to_ien_i),
    .card_ien_i (card_ien_i),
    .to_o       (to_o),
    .card_to_o  (card_to_o)
  );
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int NUM_TRK = 3,
  parameter int CNT_W   = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_i,
  input logic [NUM_TRK-1:0]       peak_i,
  input logic [NUM_TRK-1:0]       xing_i,
  input logic [NUM_TRK-1:0]       dt_we_o,
  input logic [NUM_TRK*CNT_W-1:0] dt_data_o,
  input logic [NUM_TRK-1:0]       to_o,
  input logic                     card_to_o
);
  // input assumption: pulses only arrive with a strobe
  assert_pulse_on_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((peak_i != '0) || (xing_i != '0)) |-> sample_i);

  assert_no_out_without_sample_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_i) |-> (dt_we_o == '0) && (to_o == '0) && !card_to_o);

  assert_card_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_to_o |=> !card_to_o);

  for (genvar g = 0; g < NUM_TRK; g++) begin : g_chk
    assert_to_writes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      to_o[g] |-> dt_we_o[g]);
    assert_to_parked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      to_o[g] |=> !to_o[g]);
    assert_delta_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dt_we_o[g] |-> (dt_data_o[g*CNT_W +: CNT_W] != '0));
  end
endmodule

bind pit_timer pit_timer_chk #(.NUM_TRK(NUM_TRK), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sample_i  (sample_i),
  .peak_i    (peak_i),
  .xing_i    (xing_i),
  .dt_we_o   (dt_we_o),
  .dt_data_o (dt_data_o),
  .to_o      (to_o),
  .card_to_o (card_to_o)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sample_i = 1'b0;
  logic [2:0]  peak_i = '0, xing_i = '0;
  logic [2:0]  trk_en_i = 3'b111;
  logic [11:0] max_cnt_i = 12'd100;
  logic [2:0]  to_ien_i = 3'b111;
  logic        card_ien_i = 1'b1;
  logic [2:0]  dt_we_o, to_o;
  logic [35:0] dt_data_o;
  logic        card_to_o;

  int checks = 0, errors = 0;
  logic [2:0]  g_we, g_to;
  logic        g_card;
  logic [35:0] g_data;

  pit_timer u_dut (.*);

  always #10 clk_i = ~clk_i;

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // one cycle; s=1 gives a sample strobe with the given pulses
  task automatic cyc(logic s, logic [2:0] pk, logic [2:0] xg);
    sample_i = s; peak_i = pk; xing_i = xg;
    @(negedge clk_i);
    g_we = dt_we_o; g_to = to_o; g_card = card_to_o; g_data = dt_data_o;
    sample_i = 1'b0; peak_i = '0; xing_i = '0;
  endtask

  task automatic tick(logic [2:0] pk = '0, logic [2:0] xg = '0);
    cyc(1'b1, pk, xg);
  endtask

  function automatic int dat(int n);
    return int'(g_data[n*12 +: 12]);
  endfunction

  task automatic do_reset(logic [11:0] mx);
    rst_ni = 1'b0; trk_en_i = 3'b111; to_ien_i = 3'b111; card_ien_i = 1'b1;
    max_cnt_i = mx;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset;
    int any = 0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1 outputs in reset", {dt_we_o, to_o, card_to_o}, 0);
    do_reset(12'd3);
    for (int i = 0; i < 8; i++) begin
      tick();
      any |= {g_we, g_to, g_card};
    end
    chk("R1 R2 no output before first peak", any, 0);
  endtask

  task automatic t_delta;
    do_reset(12'd100);
    tick(3'b001);
    chk("R2 first peak no write", g_we, 0);
    cyc(0, 0, 0); tick(); cyc(0, 0, 0); tick(); tick(); tick();
    chk("R3 no write between peaks", g_we, 0);
    tick(3'b001);
    chk("R3 write strobe", g_we, 3'b001);
    chk("R3 delta value", dat(0), 5);
    cyc(0, 0, 0);
    chk("R11 strobe one cycle", g_we, 0);
    tick(3'b001);
    chk("R3 restart same strobe", dat(0), 1);
  endtask

  task automatic t_timeout;
    int any = 0;
    do_reset(12'd6);
    tick(3'b001);
    for (int i = 0; i < 5; i++) tick();
    chk("R4 no early time-out", g_to, 0);
    tick();
    chk("R4 time-out pulse", g_to, 3'b001);
    chk("R4 final write", g_we, 3'b001);
    chk("R4 final delta equals max", dat(0), 6);
    chk("R7 card on only track", g_card, 1);
    cyc(0, 0, 0);
    chk("R11 time-out one cycle", {g_to, g_card}, 0);
    for (int i = 0; i < 20; i++) begin
      tick(3'b001);
      any |= {g_we, g_to, g_card};
    end
    chk("R5 parked track silent", any, 0);
    // re-arm; crossing while timing must not restart
    tick(3'b000, 3'b001);
    tick(3'b000, 3'b001);
    tick();
    tick(3'b001);
    chk("R6 re-armed delta", dat(0), 3);
    chk("R6 re-armed write", g_we, 3'b001);
  endtask

  task automatic t_card_block;
    do_reset(12'd4);
    tick(3'b001);
    tick(3'b010);
    tick(); tick(); tick();
    chk("R7 track0 time-out", g_to, 3'b001);
    chk("R7 no card while track1 timing", g_card, 0);
    tick();
    chk("R7 track1 time-out", g_to, 3'b010);
    chk("R7 card on last track", g_card, 1);
    chk("R4 track1 delta", dat(1), 4);
  endtask

  task automatic t_simul;
    int n = 0;
    do_reset(12'd3);
    tick(3'b011);
    tick(); tick(); tick();
    chk("R8 both time out", g_to, 3'b011);
    chk("R8 card pulse", g_card, 1);
    for (int i = 0; i < 5; i++) begin
      tick();
      n += int'(g_card);
    end
    chk("R8 single card pulse", n, 0);
  endtask

  task automatic t_ien;
    do_reset(12'd2);
    to_ien_i = 3'b010; card_ien_i = 1'b0;
    tick(3'b001); tick(); tick();
    chk("R9 write kept", g_we, 3'b001);
    chk("R9 time-out gated", g_to, 0);
    chk("R9 card gated", g_card, 0);
    to_ien_i = 3'b000; card_ien_i = 1'b1;
    tick(3'b000, 3'b001); tick(); tick();
    chk("R9 card enabled alone", {g_to, g_card}, 1);
    chk("R9 write with enables off", g_we, 3'b001);
  endtask

  task automatic t_disable;
    int any = 0;
    do_reset(12'd5);
    tick(3'b011); tick();
    trk_en_i = 3'b001;
    for (int i = 0; i < 3; i++) begin
      tick(3'b010);
      any |= int'(g_we[1] | g_to[1]);
    end
    tick();
    any |= int'(g_we[1] | g_to[1]);
    chk("R10 disabled track silent", any, 0);
    chk("R10 track0 time-out", g_to, 3'b001);
    chk("R10 card with track1 disabled", g_card, 1);
    trk_en_i = 3'b111;
    tick(3'b010); tick(3'b010);
    chk("R10 re-enabled needs first peak", dat(1), 1);
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_delta();
    t_timeout();
    t_card_block();
    t_simul();
    t_ien();
    t_disable();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule